// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the host-visible control and status register bank for one DMA channel. A host bus reads and writes it in 16-bit or 32-bit accesses, addressed by word index. It holds the channel's pointers, configuration, X and Y counts and strides, the live current-state values, a status word and a peripheral routing word. Every value is exported as a port for the transfer engine. The engine writes the current-state values back, and it reports completion and errors through dedicated inputs.

A write to the configuration register starts or stops the channel. If the written enable bit is set, the channel enters the running state and the loader gets a one-cycle start pulse. If the enable bit is clear, the running state ends and a one-cycle stop pulse cancels any pending work. While the channel is running, host writes to the setup and current-state registers are dropped. The configuration and status registers stay writable at all times. Status flags are cleared by writing ones to them. Writes to unused word slots are rejected and reported on a one-cycle pulse.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register reads as zero, except the peripheral word, which reads as the parameter PMAP_RST (default 0x0040). The channel is not running and all pulses are low.
- R2: The byte offsets are fixed as follows: next descriptor 0x00, start address 0x04, configuration 0x08, X count 0x10, X stride 0x14, Y count 0x18, Y stride 0x1C, current descriptor 0x20, current address 0x24, status 0x28, peripheral word 0x2C, current X count 0x30, current Y count 0x38. The host addresses them by word index, which is the offset divided by 4.
- R3: The four 32-bit pointer registers (next descriptor, start, current descriptor, current address) accept a 32-bit write in full. A 16-bit write replaces bits 15:0 and keeps bits 31:16.
- R4: While RUN is set, host writes to the pointers, the counts, the strides, the peripheral word and the current counts are discarded.
- R5: The status word has DONE at bit 0, ERR at bit 1 and RUN at bit 3. A host write clears DONE or ERR only where the written data has a 1. RUN and all other status bits ignore host writes to the status word.
- R6: A host write to the peripheral word keeps the channel-type bit (bit PMAP_CT, default 6) and replaces all other bits.
- R7: The configuration register is always writable. If written bit 0 (enable) is 1, RUN is 1 and start_pulse is high for one cycle after the write edge. If bit 0 is 0, RUN is 0 and stop_pulse is high for one cycle.
- R8: A 32-bit read returns the whole register. A 16-bit read returns bits 15:0, zero-extended. Reserved word indexes 3, 13 and 15 read as zero.
- R9: A write to reserved index 3, 13 or 15 changes no register and raises bad_wr_pulse for exactly one cycle.
- R10: An eng_ld pulse loads the current descriptor, current address and both current counts, even while RUN is set. eng_done sets DONE and clears RUN. eng_err sets ERR. An engine set wins over a host clear in the same cycle.
- R11: A 32-bit write to a 16-bit register stores bits 15:0 of the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_wr | input | 1 | Host write strobe |
| hb_addr | input | 4 | Host word index (byte offset bits 5:2) |
| hb_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Host read data, combinational from hb_addr |
| eng_ld | input | 1 | Engine load of current-state values |
| eng_cdesc | input | 32 | Engine current descriptor value |
| eng_caddr | input | 32 | Engine current address value |
| eng_cxcnt | input | 16 | Engine current X count |
| eng_cycnt | input | 16 | Engine current Y count |
| eng_done | input | 1 | Engine completion event |
| eng_err | input | 1 | Engine error event |
| o_ndesc | output | 32 | Next descriptor pointer |
| o_start | output | 32 | Start address |
| o_cfg | output | 16 | Configuration |
| o_xcnt | output | 16 | X count |
| o_xmod | output | 16 | X stride |
| o_ycnt | output | 16 | Y count |
| o_ymod | output | 16 | Y stride |
| o_cdesc | output | 32 | Current descriptor pointer |
| o_caddr | output | 32 | Current address |
| o_cxcnt | output | 16 | Current X count |
| o_cycnt | output | 16 | Current Y count |
| o_pmap | output | 16 | Peripheral word |
| o_running | output | 1 | RUN status |
| start_pulse | output | 1 | One-cycle start request to the loader |
| stop_pulse | output | 1 | One-cycle cancel request |
| bad_wr_pulse | output | 1 | One-cycle reserved-write flag |

## Verification
The bench interleaves random writes and reads at all sixteen indexes and both widths with an enable-driven RUN state. This exposes a lock keyed to the wrong condition: such a design would either accept setup writes during a transfer or refuse them once stopped. Directed cases target three further errors. A 16-bit pointer write that clobbered the upper half would show in the read-back. A peripheral write that altered the channel-type bit would show in the read-back. A status write that cleared RUN or flags written with 0 would show in the status word. The bench also drives an engine event in the same cycle as a host clear, so a design giving the host priority would lose ERR. Reserved slots are written with random data and read back, so a design that let these writes alias onto neighbours, or that omitted the invalid-write pulse, would fail.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int IX_NDESC = 0;
  localparam int IX_START = 1;
  localparam int IX_CFG   = 2;
  localparam int IX_RSV0  = 3;
  localparam int IX_XCNT  = 4;
  localparam int IX_XMOD  = 5;
  localparam int IX_YCNT  = 6;
  localparam int IX_YMOD  = 7;
  localparam int IX_CDESC = 8;
  localparam int IX_CADDR = 9;
  localparam int IX_STAT  = 10;
  localparam int IX_PMAP  = 11;
  localparam int IX_CXCNT = 12;
  localparam int IX_RSV1  = 13;
  localparam int IX_CYCNT = 14;
  localparam int IX_RSV2  = 15;

  localparam int ST_DONE = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_RUN  = 3;
  localparam int CFG_EN  = 0;
endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
  import dma_regs_pkg::*;
#(
  parameter int IXW = 4,
  localparam int NSLOT = 2 ** IXW
) (
  input  logic             hb_wr,
  input  logic [IXW-1:0]   ix,
  output logic [NSLOT-1:0] wsel,
  output logic             wr_bad
);
  always_comb begin
    wsel = '0;
    if (hb_wr) wsel[ix] = 1'b1;
    wr_bad = wsel[IX_RSV0] | wsel[IX_RSV1] | wsel[IX_RSV2];
  end
endmodule

// File: rtl/dma_ptr_reg.sv
module dma_ptr_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] RST = '0,
  localparam int H = W / 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_we,
  input  logic         host_wide,
  input  logic [W-1:0] host_data,
  input  logic         eng_we,
  input  logic [W-1:0] eng_data,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = eng_we | host_we;
    q_d  = q;
    if (eng_we)         q_d = eng_data;
    else if (host_we)   q_d = host_wide ? host_data : {q[W-1:H], host_data[H-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST;
    else if (q_en) q <= q_d;
  end

  assert_half_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !host_wide && !eng_we) |=> (q[W-1:H] == $past(q[W-1:H])));
endmodule

// File: rtl/dma_run_ctl.sv
module dma_run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_en,
  input  logic stat_we,
  input  logic clr_done,
  input  logic clr_err,
  input  logic eng_done,
  input  logic eng_err,
  output logic run_q,
  output logic done_q,
  output logic err_q,
  output logic start_q,
  output logic stop_q
);
  logic run_d, done_d, err_d, start_d, stop_d;

  always_comb begin
    run_d = run_q;
    if (eng_done) run_d = 1'b0;
    if (cfg_we)   run_d = cfg_en;
    done_d  = (done_q & ~(stat_we & clr_done)) | eng_done;
    err_d   = (err_q & ~(stat_we & clr_err)) | eng_err;
    start_d = cfg_we & cfg_en;
    stop_d  = cfg_we & ~cfg_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      start_q <= 1'b0; stop_q <= 1'b0;
    end else begin
      run_q <= run_d; done_q <= done_d; err_q <= err_d;
      start_q <= start_d; stop_q <= stop_d;
    end
  end

  assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_en) |=> (run_q && start_q && !stop_q));
  assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_en) |=> (!run_q && stop_q && !start_q));
  assert_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !cfg_we) |=> (done_q && !run_q));
  assert_err_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_err |=> err_q);
  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && !cfg_we && !eng_done) |=> (run_q == $past(run_q)));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int PMAP_CT = 6,
  parameter logic [DW/2-1:0] PMAP_RST = 16'h0040,
  localparam int HW = DW / 2,
  localparam int IXW = AW - 2,
  localparam int NSLOT = 2 ** IXW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hb_wr,
  input  logic [AW-1:2] hb_addr,
  input  logic          hb_wide,
  input  logic [DW-1:0] hb_wdata,
  output logic [DW-1:0] hb_rdata,
  input  logic          eng_ld,
  input  logic [DW-1:0] eng_cdesc,
  input  logic [DW-1:0] eng_caddr,
  input  logic [HW-1:0] eng_cxcnt,
  input  logic [HW-1:0] eng_cycnt,
  input  logic          eng_done,
  input  logic          eng_err,
  output logic [DW-1:0] o_ndesc,
  output logic [DW-1:0] o_start,
  output logic [HW-1:0] o_cfg,
  output logic [HW-1:0] o_xcnt,
  output logic [HW-1:0] o_xmod,
  output logic [HW-1:0] o_ycnt,
  output logic [HW-1:0] o_ymod,
  output logic [DW-1:0] o_cdesc,
  output logic [DW-1:0] o_caddr,
  output logic [HW-1:0] o_cxcnt,
  output logic [HW-1:0] o_cycnt,
  output logic [HW-1:0] o_pmap,
  output logic          o_running,
  output logic          start_pulse,
  output logic          stop_pulse,
  output logic          bad_wr_pulse
);
  localparam logic [HW-1:0] CT_MASK = HW'(1) << PMAP_CT;

  logic [NSLOT-1:0] wsel;
  logic             wr_bad;
  logic             run_q, done_q, err_q;
  logic             bad_d;
  logic [DW-1:0]    ptr_q [4];
  logic [HW-1:0]    half_q [7];
  logic [HW-1:0]    pmap_q, pmap_d;
  logic             pmap_we;

  dma_reg_decode #(.IXW(IXW)) dec_i (
    .hb_wr(hb_wr), .ix(hb_addr), .wsel(wsel), .wr_bad(wr_bad));

  // Pointer registers: index map k -> slot, engine loads only current ones
  localparam int PTR_IX [4] = '{IX_NDESC, IX_START, IX_CDESC, IX_CADDR};
  logic [DW-1:0] ptr_eng [4];
  assign ptr_eng[0] = '0;
  assign ptr_eng[1] = '0;
  assign ptr_eng[2] = eng_cdesc;
  assign ptr_eng[3] = eng_caddr;

  for (genvar k = 0; k < 4; k++) begin : g_ptr
    dma_ptr_reg #(.W(DW)) ptr_i (
      .clk(clk), .rst_n(rst_n),
      .host_we(wsel[PTR_IX[k]] & ~run_q), .host_wide(hb_wide),
      .host_data(hb_wdata), .eng_we(eng_ld & (k >= 2)),
      .eng_data(ptr_eng[k]), .q(ptr_q[k]));
  end

  // 16-bit registers: config (never locked), counts, strides, current counts
  localparam int HALF_IX [7] = '{IX_CFG, IX_XCNT, IX_XMOD, IX_YCNT, IX_YMOD, IX_CXCNT, IX_CYCNT};
  logic [HW-1:0] half_eng [7];
  always_comb begin
    for (int k = 0; k < 7; k++) half_eng[k] = '0;
    half_eng[5] = eng_cxcnt;
    half_eng[6] = eng_cycnt;
  end

  for (genvar k = 0; k < 7; k++) begin : g_half
    logic          we_k, en_k;
    logic [HW-1:0] d_k;
    assign we_k = wsel[HALF_IX[k]] & ((k == 0) | ~run_q);
    always_comb begin
      en_k = we_k | (eng_ld & (k >= 5));
      d_k  = (eng_ld && k >= 5) ? half_eng[k] : hb_wdata[HW-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    half_q[k] <= '0;
      else if (en_k) half_q[k] <= d_k;
    end
  end

  // Peripheral word with protected channel-type bit
  always_comb begin
    pmap_we = wsel[IX_PMAP] & ~run_q;
    pmap_d  = (hb_wdata[HW-1:0] & ~CT_MASK) | (pmap_q & CT_MASK);
    bad_d   = wr_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmap_q       <= PMAP_RST;
      bad_wr_pulse <= 1'b0;
    end else begin
      if (pmap_we) pmap_q <= pmap_d;
      bad_wr_pulse <= bad_d;
    end
  end

  dma_run_ctl ctl_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(wsel[IX_CFG]), .cfg_en(hb_wdata[CFG_EN]),
    .stat_we(wsel[IX_STAT]), .clr_done(hb_wdata[ST_DONE]), .clr_err(hb_wdata[ST_ERR]),
    .eng_done(eng_done), .eng_err(eng_err),
    .run_q(run_q), .done_q(done_q), .err_q(err_q),
    .start_q(start_pulse), .stop_q(stop_pulse));

  // Read path
  logic [DW-1:0] rword;
  logic [HW-1:0] stat_w;
  always_comb begin
    stat_w = '0;
    stat_w[ST_DONE] = done_q;
    stat_w[ST_ERR]  = err_q;
    stat_w[ST_RUN]  = run_q;
    rword = '0;
    case (int'(hb_addr))
      IX_NDESC: rword = ptr_q[0];
      IX_START: rword = ptr_q[1];
      IX_CFG:   rword = DW'(half_q[0]);
      IX_XCNT:  rword = DW'(half_q[1]);
      IX_XMOD:  rword = DW'(half_q[2]);
      IX_YCNT:  rword = DW'(half_q[3]);
      IX_YMOD:  rword = DW'(half_q[4]);
      IX_CDESC: rword = ptr_q[2];
      IX_CADDR: rword = ptr_q[3];
      IX_STAT:  rword = DW'(stat_w);
      IX_PMAP:  rword = DW'(pmap_q);
      IX_CXCNT: rword = DW'(half_q[5]);
      IX_CYCNT: rword = DW'(half_q[6]);
      default:  rword = '0;
    endcase
    hb_rdata = hb_wide ? rword : DW'(rword[HW-1:0]);
  end

  assign o_ndesc = ptr_q[0];
  assign o_start = ptr_q[1];
  assign o_cdesc = ptr_q[2];
  assign o_caddr = ptr_q[3];
  assign o_cfg   = half_q[0];
  assign o_xcnt  = half_q[1];
  assign o_xmod  = half_q[2];
  assign o_ycnt  = half_q[3];
  assign o_ymod  = half_q[4];
  assign o_cxcnt = half_q[5];
  assign o_cycnt = half_q[6];
  assign o_pmap  = pmap_q;
  assign o_running = run_q;

  assert_lock_xcnt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && hb_wr && int'(hb_addr) == IX_XCNT) |=> $stable(o_xcnt));
  assert_ct_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_wr && int'(hb_addr) == IX_PMAP) |=> (o_pmap[PMAP_CT] == $past(o_pmap[PMAP_CT])));
  assert_bad_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_wr && (int'(hb_addr) == IX_RSV0 || int'(hb_addr) == IX_RSV1 || int'(hb_addr) == IX_RSV2))
      |=> bad_wr_pulse);
  assert_bad_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hb_wr |=> !bad_wr_pulse);
endmodule

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb_top;
  localparam int CLK_P = 10;
  localparam int CT = 6;
  localparam logic [15:0] PM_RST = 16'h0040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hb_wr = 1'b0, hb_wide = 1'b0;
  logic [3:0] hb_addr = '0;
  logic [31:0] hb_wdata = '0, hb_rdata;
  logic eng_ld = 1'b0, eng_done = 1'b0, eng_err = 1'b0;
  logic [31:0] eng_cdesc = '0, eng_caddr = '0;
  logic [15:0] eng_cxcnt = '0, eng_cycnt = '0;
  logic [31:0] o_ndesc, o_start, o_cdesc, o_caddr;
  logic [15:0] o_cfg, o_xcnt, o_xmod, o_ycnt, o_ymod, o_cxcnt, o_cycnt, o_pmap;
  logic o_running, start_pulse, stop_pulse, bad_wr_pulse;

  dma_chan_regs dut_i (
    .clk(clk), .rst_n(rst_n), .hb_wr(hb_wr), .hb_addr(hb_addr), .hb_wide(hb_wide),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .eng_ld(eng_ld), .eng_cdesc(eng_cdesc),
    .eng_caddr(eng_caddr), .eng_cxcnt(eng_cxcnt), .eng_cycnt(eng_cycnt),
    .eng_done(eng_done), .eng_err(eng_err), .o_ndesc(o_ndesc), .o_start(o_start),
    .o_cfg(o_cfg), .o_xcnt(o_xcnt), .o_xmod(o_xmod), .o_ycnt(o_ycnt), .o_ymod(o_ymod),
    .o_cdesc(o_cdesc), .o_caddr(o_caddr), .o_cxcnt(o_cxcnt), .o_cycnt(o_cycnt),
    .o_pmap(o_pmap), .o_running(o_running), .start_pulse(start_pulse),
    .stop_pulse(stop_pulse), .bad_wr_pulse(bad_wr_pulse));

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0, nbad = 0;
  bit ended = 0;
  logic [31:0] m [16];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_rsv(input int ix);
    return ix == 3 || ix == 13 || ix == 15;
  endfunction

  function automatic logic [31:0] exp_read(input int ix, input bit wide);
    if (is_rsv(ix)) return 32'h0;
    return wide ? m[ix] : {16'h0, m[ix][15:0]};
  endfunction

  task automatic mupd(input int ix, input bit wide, input logic [31:0] d);
    bit lock = m[10][3];
    case (ix)
      0, 1, 8, 9: if (!lock) m[ix] = wide ? d : {m[ix][31:16], d[15:0]};
      2: begin m[2] = {16'h0, d[15:0]}; m[10][3] = d[0]; end
      4, 5, 6, 7, 12, 14: if (!lock) m[ix] = {16'h0, d[15:0]};
      10: begin
        if (d[0]) m[10][0] = 1'b0;
        if (d[1]) m[10][1] = 1'b0;
      end
      11: if (!lock) m[11] = {16'h0, (d[15:0] & ~(16'h1 << CT)) | (m[11][15:0] & (16'h1 << CT))};
      default: ;
    endcase
  endtask

  task automatic hwrite(input int ix, input bit wide, input logic [31:0] d);
    bit es, ep, eb;
    es = (ix == 2) && d[0];
    ep = (ix == 2) && !d[0];
    eb = is_rsv(ix);
    @(negedge clk);
    hb_wr = 1'b1; hb_addr = 4'(ix); hb_wide = wide; hb_wdata = d;
    mupd(ix, wide, d);
    @(negedge clk);
    hb_wr = 1'b0;
    chk("R7 start", {31'h0, start_pulse}, {31'h0, es});
    chk("R7 stop", {31'h0, stop_pulse}, {31'h0, ep});
    chk("R9 bad pulse", {31'h0, bad_wr_pulse}, {31'h0, eb});
  endtask

  task automatic hread(input int ix, input bit wide, input string req);
    @(negedge clk);
    hb_addr = 4'(ix); hb_wide = wide;
    #1;
    chk(req, hb_rdata, exp_read(ix, wide));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!ended) begin
      ended = 1;
      nbad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5151));
    for (int i = 0; i < 16; i++) m[i] = 32'h0;
    m[11] = {16'h0, PM_RST};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 16; i++) hread(i, 1'b1, "R1 reset value");
    chk("R1 running", {31'h0, o_running}, 32'h0);
    chk("R1 pulses", {29'h0, start_pulse, stop_pulse, bad_wr_pulse}, 32'h0);

    // R2/R3 pointer half writes
    hwrite(0, 1'b1, 32'hA5A5_1234);
    hwrite(0, 1'b0, 32'hFFFF_BEEF);
    hread(0, 1'b1, "R3 half write keeps upper");
    hwrite(9, 1'b1, 32'h0000_1000);
    hread(9, 1'b1, "R2 current address offset");
    // R11 wide write to half register
    hwrite(4, 1'b1, 32'hDEAD_0077);
    hread(4, 1'b1, "R11 wide write to 16-bit reg");
    chk("R2 xcnt port", {16'h0, o_xcnt}, 32'h0077);
    // R8 narrow read
    hread(0, 1'b0, "R8 narrow read");
    // R6 channel-type bit kept
    hwrite(11, 1'b1, 32'h0000_FF00);
    hread(11, 1'b1, "R6 ct bit kept set");
    chk("R6 pmap port", {16'h0, o_pmap}, m[11]);
    // R9 reserved writes
    hwrite(3, 1'b1, 32'hFFFF_FFFF);
    hread(3, 1'b1, "R9 reserved reads zero");
    hread(2, 1'b1, "R9 neighbour untouched");
    hread(4, 1'b1, "R9 neighbour untouched");
    @(negedge clk);
    chk("R9 pulse one cycle", {31'h0, bad_wr_pulse}, 32'h0);

    // R7/R4 start and lock
    hwrite(2, 1'b0, 32'h0000_0005);
    chk("R7 running", {31'h0, o_running}, 32'h1);
    hwrite(5, 1'b0, 32'h0000_1111);
    hread(5, 1'b1, "R4 stride locked");
    hwrite(1, 1'b1, 32'h1234_5678);
    hread(1, 1'b1, "R4 start locked");
    hwrite(11, 1'b0, 32'h0000_0000);
    hread(11, 1'b1, "R4 pmap locked");
    // R10 engine load while running
    @(negedge clk);
    eng_ld = 1'b1; eng_cdesc = 32'h0000_4000; eng_caddr = 32'h0000_8008;
    eng_cxcnt = 16'h0010; eng_cycnt = 16'h0003;
    m[8] = 32'h0000_4000; m[9] = 32'h0000_8008; m[12] = 32'h10; m[14] = 32'h3;
    @(negedge clk); eng_ld = 1'b0;
    hread(8, 1'b1, "R10 engine cdesc");
    hread(9, 1'b1, "R10 engine caddr");
    hread(12, 1'b1, "R10 engine cxcnt");
    hread(14, 1'b1, "R10 engine cycnt");
    // R5 status write does not clear RUN
    hwrite(10, 1'b1, 32'hFFFF_FFFF);
    hread(10, 1'b1, "R5 run not host writable");
    // R10 done
    @(negedge clk); eng_done = 1'b1; m[10][0] = 1'b1; m[10][3] = 1'b0;
    @(negedge clk); eng_done = 1'b0;
    hread(10, 1'b1, "R10 done sets, run clears");
    chk("R10 running low", {31'h0, o_running}, 32'h0);
    // R10 err set beats host clear in same cycle, R5 W1C only where 1
    @(negedge clk);
    hb_wr = 1'b1; hb_addr = 4'd10; hb_wide = 1'b0; hb_wdata = 32'h0000_0002; eng_err = 1'b1;
    m[10][1] = 1'b1;
    @(negedge clk); hb_wr = 1'b0; eng_err = 1'b0;
    hread(10, 1'b1, "R10 engine set wins");
    hwrite(10, 1'b0, 32'h0000_0001);
    hread(10, 1'b1, "R5 clear done only");
    hwrite(10, 1'b0, 32'h0000_0002);
    hread(10, 1'b1, "R5 clear err");
    // R7 stop
    hwrite(2, 1'b0, 32'h0000_0005);
    hwrite(2, 1'b1, 32'h0000_0004);
    chk("R7 stopped", {31'h0, o_running}, 32'h0);
    hwrite(5, 1'b0, 32'h0000_2222);
    hread(5, 1'b1, "R4 unlocked after stop");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int ix = int'($urandom_range(0, 15));
      bit wide = 1'($urandom_range(0, 1));
      logic [31:0] d = $urandom();
      if ($urandom_range(0, 2) == 0) begin
        if (ix == 2 && $urandom_range(0, 1) == 0) d[0] = 1'b0;
        hwrite(ix, wide, d);
      end else begin
        hread(ix, wide, "R8 random read");
      end
    end
    for (int i = 0; i < 16; i++) hread(i, 1'b1, "R2 final sweep");

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule